// File: doc/BRIEF.md
# Bit Alias Memory Bridge

This bridge sits between a single bus master and a single-port synchronous SRAM. Requests that fall in the plain memory window are forwarded as ordinary sized reads and writes. A second, larger address window gives every bit of the plain window a word address of its own. A read there returns that one bit as a word of value 0 or 1. A write there changes only that bit, so software can set or clear a flag without doing its own mask-and-merge.

Each access to the alias window becomes one access to the SRAM, at the size the master asked for. An alias write runs as a read cycle followed at once by a write-back cycle. No other access can come between the two cycles, so the update cannot be split. Addresses that hit neither window finish with zero data and never reach the SRAM.

Alias addressing: for an alias address A, the offset A - ALIAS_BASE is taken. Bits [NORM_BITS+4:5] of that offset give the target byte offset. Bits [4:2] of the offset give the bit number inside that byte. The SRAM is little-endian. Byte offset b is word b/4, lane b mod 4, so the selected bit sits at position 8*(b mod 4) + n of that word.

Top module: `bb_alias_bridge`

## Requirements
- R1: While rst_n is low, req_ready and mem_en are both low. A rising clock edge with rst_n low returns the bridge to idle, and any alias write that is in progress is dropped without a memory write.
- R2: A read in the plain window [NORM_BASE, NORM_BASE + 2^NORM_BITS) makes one SRAM read at word index (addr - NORM_BASE)/4. req_ready rises in the next cycle, and rsp_rdata then carries the full SRAM word.
- R3: A write in the plain window makes exactly one SRAM write. The byte enables follow req_size: 0 (byte) gives lane addr[1:0]; 1 (halfword) gives 4'b0011 or 4'b1100, chosen by addr[1]; 2 or 3 (word) gives 4'b1111. Only the enabled bytes change.
- R4: An alias read makes one SRAM read and no SRAM write. rsp_rdata[0] is the selected memory bit and rsp_rdata[31:1] are zero.
- R5: An alias write sets the selected memory bit to req_wdata[0]. Every other memory bit keeps its value, and req_wdata[31:1] has no effect.
- R6: Alias accesses drive the SRAM byte enables from req_size and the lane of the target byte, using the same rule as R3. The bit result does not depend on the access size.
- R7: An alias write is one SRAM read followed in the very next cycle by one SRAM write. Both cycles use the same word address and the same byte enables. req_ready is high only in the write cycle.
- R8: An address outside both windows causes no SRAM cycle. The access completes in the next cycle with rsp_rdata equal to zero.
- R9: Every access is accepted in the cycle in which req_valid is seen while idle. req_ready is high for exactly one cycle, one cycle later, and is never high on two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present; held with its fields until req_ready |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_we | input | 1 | 1 for write |
| req_wdata | input | 32 | Write data on its byte lanes; alias writes use bit 0 only |
| req_ready | output | 1 | Access completes at the next rising edge |
| rsp_rdata | output | 32 | Read data, valid while req_ready is high |
| mem_en | output | 1 | SRAM cycle enable |
| mem_we | output | 1 | SRAM write |
| mem_addr | output | NORM_BITS-2 | SRAM word address |
| mem_be | output | 4 | SRAM byte enables |
| mem_wdata | output | 32 | SRAM write data |
| mem_rdata | input | 32 | SRAM read data, one cycle after a read |

## Verification
The bench builds the bridge with NORM_BITS set to 12, a 4 KiB plain window and a 128 KiB alias window, and keeps the default base addresses. At that size the bench's SRAM model covers the whole plain window. This puts the topmost byte and bit of both windows in reach, along with the first address past each window. It also allows a full 32-bit word to be built or read back one alias bit at a time, at each access size.

// File: rtl/bb_pkg.sv
`timescale 1ns/1ps
// bb_pkg: shared types and helpers for the bit alias bridge.
// Assumes a 32-bit little-endian data path with four byte lanes.
package bb_pkg;

    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_PLAIN = 2'd1,
        KIND_BIT   = 2'd2
    } bb_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PLAIN = 3'd1,
        ST_BITRD = 3'd2,
        ST_WBACK = 3'd3,
        ST_NONE  = 3'd4
    } bb_state_e;

    // Byte enables for an access of the given size that touches the given lane.
    function automatic logic [3:0] lane_mask(input logic [1:0] size, input logic [1:0] lane);
        logic [3:0] m;
        case (size)
            2'd0:    m = 4'b0001 << lane;
            2'd1:    m = lane[1] ? 4'b1100 : 4'b0011;
            default: m = 4'b1111;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/bb_decode.sv
`timescale 1ns/1ps
// bb_decode: sorts a request address into plain window, alias window or
// neither. It produces the SRAM word address, byte enables and the bit
// position inside the word. Assumes both bases are aligned to their
// window sizes and that the two windows do not overlap.
module bb_decode
    import bb_pkg::*;
#(
    parameter logic [31:0] NORM_BASE  = 32'h2000_0000,
    parameter int          NORM_BITS  = 20,
    parameter logic [31:0] ALIAS_BASE = 32'h2200_0000
) (
    input  logic [31:0]          addr,
    input  logic [1:0]           size,
    output bb_kind_e             kind,
    output logic [NORM_BITS-3:0] word_addr,
    output logic [3:0]           be,
    output logic [4:0]           bit_sel
);
    localparam int ALIAS_BITS = NORM_BITS + 5;

    logic                 norm_hit;
    logic                 alias_hit;
    logic [NORM_BITS-1:0] byte_off;
    logic [2:0]           bit_in_byte;

    // Window compare and byte-offset selection.
    always_comb begin
        norm_hit  = (addr[31:NORM_BITS]  == NORM_BASE[31:NORM_BITS]);
        alias_hit = (addr[31:ALIAS_BITS] == ALIAS_BASE[31:ALIAS_BITS]);
        if (alias_hit) begin
            byte_off    = addr[ALIAS_BITS-1:5];
            bit_in_byte = addr[4:2];
            kind        = KIND_BIT;
        end else begin
            byte_off    = addr[NORM_BITS-1:0];
            bit_in_byte = 3'd0;
            kind        = norm_hit ? KIND_PLAIN : KIND_NONE;
        end
    end

    // Word address, lane enables and bit position from the byte offset.
    always_comb begin
        word_addr = byte_off[NORM_BITS-1:2];
        be        = lane_mask(size, byte_off[1:0]);
        bit_sel   = {byte_off[1:0], bit_in_byte};
    end

endmodule

// File: rtl/bb_bitmerge.sv
`timescale 1ns/1ps
// bb_bitmerge: picks one bit out of a data word, and builds the same word
// with that one bit replaced. Assumes DW is a power of two.
module bb_bitmerge #(
    parameter int DW = 32,
    localparam int SW = $clog2(DW)
) (
    input  logic [DW-1:0] word,
    input  logic [SW-1:0] bit_sel,
    input  logic          new_bit,
    output logic          picked,
    output logic [DW-1:0] merged
);
    // Selected bit of the incoming word.
    always_comb picked = word[bit_sel];

    // One replace mux per bit position.
    for (genvar gi = 0; gi < DW; gi++) begin : g_bit
        always_comb merged[gi] = (bit_sel == SW'(gi)) ? new_bit : word[gi];
    end

endmodule

// File: rtl/bb_seq.sv
`timescale 1ns/1ps
// bb_seq: access sequencer. It leaves idle for exactly one cycle per
// accepted request. An alias write is the only kind that needs a second
// SRAM cycle, and that cycle is the one in which the access completes.
// Assumes the master holds the request until it sees ready.
module bb_seq
    import bb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  bb_kind_e  kind,
    input  logic      we,
    output bb_state_e state
);
    bb_state_e state_nx;

    // Next state from the decoded request.
    always_comb begin
        state_nx = ST_IDLE;
        if (state == ST_IDLE && start) begin
            case (kind)
                KIND_PLAIN: state_nx = ST_PLAIN;
                KIND_BIT:   state_nx = we ? ST_WBACK : ST_BITRD;
                default:    state_nx = ST_NONE;
            endcase
        end
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

endmodule

// File: rtl/bb_alias_bridge.sv
`timescale 1ns/1ps
// bb_alias_bridge: top of the bit alias bridge. It issues the first SRAM
// cycle straight from the request in the idle cycle. It holds what the
// alias write-back needs and merges the write-back word from the SRAM
// read data. Assumes an SRAM with one-cycle read latency that keeps its
// read data until its next enabled cycle.
module bb_alias_bridge
    import bb_pkg::*;
#(
    parameter logic [31:0] NORM_BASE  = 32'h2000_0000,
    parameter int          NORM_BITS  = 20,
    parameter logic [31:0] ALIAS_BASE = 32'h2200_0000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [31:0]          req_addr,
    input  logic [1:0]           req_size,
    input  logic                 req_we,
    input  logic [31:0]          req_wdata,
    output logic                 req_ready,
    output logic [31:0]          rsp_rdata,
    output logic                 mem_en,
    output logic                 mem_we,
    output logic [NORM_BITS-3:0] mem_addr,
    output logic [3:0]           mem_be,
    output logic [31:0]          mem_wdata,
    input  logic [31:0]          mem_rdata
);
    localparam int WAW = NORM_BITS - 2;

    bb_kind_e       dec_kind;
    logic [WAW-1:0] dec_addr;
    logic [3:0]     dec_be;
    logic [4:0]     dec_sel;
    bb_state_e      state;
    logic [WAW-1:0] held_addr;
    logic [3:0]     held_be;
    logic [4:0]     held_sel;
    logic           held_bit;
    logic           picked;
    logic [31:0]    merged;

    bb_decode #(
        .NORM_BASE (NORM_BASE),
        .NORM_BITS (NORM_BITS),
        .ALIAS_BASE(ALIAS_BASE)
    ) u_decode (
        .addr     (req_addr),
        .size     (req_size),
        .kind     (dec_kind),
        .word_addr(dec_addr),
        .be       (dec_be),
        .bit_sel  (dec_sel)
    );

    bb_seq u_seq (
        .clk  (clk),
        .rst_n(rst_n),
        .start(req_valid),
        .kind (dec_kind),
        .we   (req_we),
        .state(state)
    );

    bb_bitmerge #(.DW(32)) u_merge (
        .word   (mem_rdata),
        .bit_sel(held_sel),
        .new_bit(held_bit),
        .picked (picked),
        .merged (merged)
    );

    // Hold the write-back target while a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_addr <= '0;
            held_be   <= '0;
            held_sel  <= '0;
            held_bit  <= 1'b0;
        end else if (state == ST_IDLE && req_valid) begin
            held_addr <= dec_addr;
            held_be   <= dec_be;
            held_sel  <= dec_sel;
            held_bit  <= req_wdata[0];
        end
    end

    // SRAM cycle: the request itself when idle, the merged word in write-back.
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = dec_addr;
        mem_be    = dec_be;
        mem_wdata = req_wdata;
        if (rst_n) begin
            if (state == ST_IDLE) begin
                mem_en = req_valid && (dec_kind != KIND_NONE);
                mem_we = req_valid && (dec_kind == KIND_PLAIN) && req_we;
            end else if (state == ST_WBACK) begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = held_addr;
                mem_be    = held_be;
                mem_wdata = merged;
            end
        end
    end

    // Completion and response data by state.
    always_comb begin
        req_ready = rst_n && (state != ST_IDLE);
        case (state)
            ST_PLAIN: rsp_rdata = mem_rdata;
            ST_BITRD: rsp_rdata = {31'd0, picked};
            default:  rsp_rdata = 32'd0;
        endcase
    end

endmodule

// File: rtl/bb_alias_bridge_chk.sv
`timescale 1ns/1ps
// bb_alias_bridge_chk: protocol checks on the bridge ports, attached by
// bind. It works out window membership from the address tags it is given.
module bb_alias_bridge_chk #(
    parameter logic [31:0] NORM_BASE  = 32'h2000_0000,
    parameter int          NORM_BITS  = 20,
    parameter logic [31:0] ALIAS_BASE = 32'h2200_0000,
    localparam int         ALIAS_BITS = NORM_BITS + 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic [31:NORM_BITS]  norm_tag,
    input logic [31:ALIAS_BITS] alias_tag,
    input logic [1:0]           req_size,
    input logic                 req_we,
    input logic                 req_ready,
    input logic [31:0]          rsp_rdata,
    input logic                 mem_en,
    input logic                 mem_we,
    input logic [NORM_BITS-3:0] mem_addr,
    input logic [3:0]           mem_be,
    input logic [31:0]          mem_wdata,
    input logic [31:0]          mem_rdata
);
    logic in_norm;
    logic in_alias;

    // Window membership of the current request.
    always_comb begin
        in_norm  = (norm_tag  == NORM_BASE[31:NORM_BITS]);
        in_alias = (alias_tag == ALIAS_BASE[31:ALIAS_BITS]);
    end

    p_ready_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

    p_alias_read_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && in_alias && !req_we) |-> (rsp_rdata[31:1] == 31'd0));

    p_one_bit_changes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we && req_ready) |-> ($countones(mem_wdata ^ mem_rdata) <= 1));

    p_wback_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we && req_ready) |->
            ($past(mem_en) && !$past(mem_we) && ($past(mem_addr) == mem_addr) && ($past(mem_be) == mem_be)));

    p_be_by_size_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && req_valid) |->
            ($countones(mem_be) == ((req_size == 2'd0) ? 1 : (req_size == 2'd1) ? 2 : 4)));

    p_outside_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !in_norm && !in_alias) |-> (!mem_en && (rsp_rdata == 32'd0)));

endmodule

bind bb_alias_bridge bb_alias_bridge_chk #(
    .NORM_BASE (NORM_BASE),
    .NORM_BITS (NORM_BITS),
    .ALIAS_BASE(ALIAS_BASE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .norm_tag (req_addr[31:NORM_BITS]),
    .alias_tag(req_addr[31:NORM_BITS+5]),
    .req_size (req_size),
    .req_we   (req_we),
    .req_ready(req_ready),
    .rsp_rdata(rsp_rdata),
    .mem_en   (mem_en),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_be   (mem_be),
    .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
);

// File: tb/tb_bb_alias_bridge.sv
`timescale 1ns/1ps
// Bench: a table of accesses checked against a reference memory, then
// directed reset, full-word and window-edge tests.
module tb_bb_alias_bridge;
    localparam logic [31:0] NB    = 32'h2000_0000;
    localparam logic [31:0] AB    = 32'h2200_0000;
    localparam int          NBITS = 12;
    localparam int          DEPTH = 1 << (NBITS - 2);
    localparam int          NT    = 15;

    // Vector fields: {addr, wdata, we, size}
    localparam logic [66:0] TBL [NT] = '{
        {32'h2000_0010, 32'h89AB_CDEF, 1'b1, 2'd2},  // R3 word write
        {32'h2000_0010, 32'h0000_0000, 1'b0, 2'd2},  // R2 word read
        {32'h2200_0214, 32'h0000_0000, 1'b0, 2'd2},  // R4 byte 0x10 bit 5
        {32'h2200_027C, 32'h0000_0000, 1'b0, 2'd0},  // R4 R6 byte 0x13 bit 7
        {32'h2200_0228, 32'hFFFF_FFFE, 1'b1, 2'd1},  // R5 R6 byte 0x11 bit 2 -> 0
        {32'h2000_0010, 32'h0000_0000, 1'b0, 2'd2},  // R2 read back
        {32'h2000_0021, 32'h0000_AB00, 1'b1, 2'd0},  // R3 byte write
        {32'h2000_0022, 32'h1234_0000, 1'b1, 2'd1},  // R3 half write
        {32'h2000_0020, 32'h0000_0000, 1'b0, 2'd3},  // R2 read, size 3
        {32'h2100_0000, 32'h0000_0000, 1'b0, 2'd2},  // R8 outside read
        {32'h3000_0000, 32'hFFFF_FFFF, 1'b1, 2'd2},  // R8 outside write
        {32'h2201_FFFC, 32'h0000_0001, 1'b1, 2'd0},  // R5 top bit of window
        {32'h2000_0FFC, 32'h0000_0000, 1'b0, 2'd2},  // R2 top word
        {32'h2202_0000, 32'h0000_0000, 1'b0, 2'd2},  // R8 just past alias window
        {32'h2000_1000, 32'h0000_0000, 1'b0, 2'd1}   // R8 just past plain window
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [31:0]      req_addr = '0;
    logic [1:0]       req_size = '0;
    logic             req_we = 1'b0;
    logic [31:0]      req_wdata = '0;
    logic             req_ready;
    logic [31:0]      rsp_rdata;
    logic             mem_en;
    logic             mem_we;
    logic [NBITS-3:0] mem_addr;
    logic [3:0]       mem_be;
    logic [31:0]      mem_wdata;
    logic [31:0]      mem_rdata = '0;

    logic [31:0] mem    [DEPTH];
    logic [31:0] shadow [DEPTH];
    int checks = 0;
    int fails = 0;
    int en_cnt = 0;
    int we_cnt = 0;
    logic [3:0] last_be = '0;
    bit done = 1'b0;

    bb_alias_bridge #(.NORM_BASE(NB), .NORM_BITS(NBITS), .ALIAS_BASE(AB)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_we(req_we), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_rdata(rsp_rdata), .mem_en(mem_en),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always #10 clk = ~clk;

    // SRAM model: read-first, one-cycle read latency, output held when idle.
    always @(posedge clk) begin
        if (mem_en) begin
            mem_rdata <= mem[mem_addr];
            if (mem_we)
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
        end
    end

    // Port monitor sampled mid-cycle.
    always @(negedge clk) begin
        #5;
        if (mem_en) en_cnt++;
        if (mem_en && mem_we) begin
            we_cnt++;
            last_be = mem_be;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] ref_be(input logic [1:0] size, input logic [1:0] lane);
        if (size == 2'd0) return 4'b0001 << lane;
        if (size == 2'd1) return lane[1] ? 4'b1100 : 4'b0011;
        return 4'b1111;
    endfunction

    task automatic run(input logic [31:0] a, input logic [31:0] wd, input logic we,
                       input logic [1:0] sz, output logic [31:0] rd, output int lat);
        @(negedge clk);
        req_addr = a; req_wdata = wd; req_we = we; req_size = sz; req_valid = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!req_ready && lat < 20);
        rd = rsp_rdata;
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    // One access with full reference checking.
    task automatic access(input logic [31:0] a, input logic [31:0] wd, input logic we, input logic [1:0] sz);
        logic [31:0] rd, exp_rd;
        int lat, e0, w0, widx, bpos, boff;
        logic [3:0] xbe;
        bit plain, alias_hit;
        e0 = en_cnt; w0 = we_cnt;
        plain     = (a >= NB) && (a < NB + (32'd1 << NBITS));
        alias_hit = (a >= AB) && (a < AB + (32'd1 << (NBITS + 5)));
        widx = 0; exp_rd = 0; xbe = 0;
        if (plain) begin
            widx = int'((a - NB) >> 2);
            xbe = ref_be(sz, a[1:0]);
            exp_rd = shadow[widx];
            if (we) for (int b = 0; b < 4; b++) if (xbe[b]) shadow[widx][8*b +: 8] = wd[8*b +: 8];
        end else if (alias_hit) begin
            boff = int'((a - AB) >> 5);
            widx = boff >> 2;
            bpos = 8 * (boff % 4) + int'((a - AB) >> 2) % 8;
            xbe = ref_be(sz, 2'(boff % 4));
            exp_rd = {31'd0, shadow[widx][bpos]};
            if (we) shadow[widx][bpos] = wd[0];
        end
        run(a, wd, we, sz, rd, lat);
        check(lat == 1, "R9 latency", 32'(lat), 32'd1);
        if (!we) check(rd == exp_rd, plain ? "R2 read data" : alias_hit ? "R4 bit read" : "R8 zero data", rd, exp_rd);
        if (plain) begin
            check(en_cnt - e0 == 1, "R2 one memory cycle", 32'(en_cnt - e0), 32'd1);
            check(we_cnt - w0 == (we ? 1 : 0), "R3 write count", 32'(we_cnt - w0), 32'(we));
            if (we) check(last_be == xbe, "R3 byte enables", 32'(last_be), 32'(xbe));
            check(mem[widx] == shadow[widx], "R3 memory word", mem[widx], shadow[widx]);
        end else if (alias_hit) begin
            check(en_cnt - e0 == (we ? 2 : 1), "R7 alias cycles", 32'(en_cnt - e0), we ? 32'd2 : 32'd1);
            check(we_cnt - w0 == (we ? 1 : 0), "R4 R7 alias writes", 32'(we_cnt - w0), 32'(we));
            if (we) check(last_be == xbe, "R6 alias byte enables", 32'(last_be), 32'(xbe));
            check(mem[widx] == shadow[widx], "R5 only target bit", mem[widx], shadow[widx]);
        end else begin
            check(en_cnt == e0, "R8 no memory cycle", 32'(en_cnt - e0), 32'd0);
        end
    endtask

    // Watchdog.
    initial begin
        #(200000 * 20);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd, v;
        int lat, w0;
        for (int i = 0; i < DEPTH; i++) begin
            mem[i]    = (32'(i) * 32'h9E37_79B1) ^ 32'h5A5A_5A5A;
            shadow[i] = mem[i];
        end
        // R1: reset holds ready and SRAM enable low even with a request present.
        req_valid = 1'b1; req_addr = NB; req_size = 2'd2;
        repeat (3) begin
            @(negedge clk);
            check(!req_ready && !mem_en, "R1 reset outputs", {30'd0, req_ready, mem_en}, 32'd0);
        end
        req_valid = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int t = 0; t < NT; t++)
            access(TBL[t][66:35], TBL[t][34:3], TBL[t][2], TBL[t][1:0]);

        // R5 R6: build a word one alias bit at a time, word size, byte 0x40.
        for (int i = 0; i < 32; i++)
            access(AB + 32'h40 * 32 + 32'(i) * 4, {31'd0, 1'(32'h1234_5678 >> i)}, 1'b1, 2'd2);
        run(NB + 32'h40, 32'd0, 1'b0, 2'd2, rd, lat);
        check(rd == 32'h1234_5678, "R5 word built from bits", rd, 32'h1234_5678);

        // R4 R6: read every bit of a known word through halfword alias reads.
        access(NB + 32'h80, 32'h89AB_CDEF, 1'b1, 2'd2);
        v = 32'd0;
        for (int i = 0; i < 32; i++) begin
            run(AB + 32'h80 * 32 + 32'(i) * 4, 32'd0, 1'b0, 2'd1, rd, lat);
            v[i] = rd[0];
            check(rd[31:1] == 0, "R4 upper bits zero", rd, {31'd0, rd[0]});
        end
        check(v == 32'h89AB_CDEF, "R6 bits gathered by halfword", v, 32'h89AB_CDEF);

        // R1: reset in the write-back cycle drops the alias write.
        w0 = we_cnt;
        @(negedge clk);
        req_addr = AB + 32'h8 * 32; req_wdata = ~{31'd0, shadow[2][0]}; req_we = 1'b1;
        req_size = 2'd0; req_valid = 1'b1;
        @(negedge clk);
        rst_n = 1'b0;
        #1 check(!req_ready && !mem_en, "R1 reset during write-back", {30'd0, req_ready, mem_en}, 32'd0);
        @(posedge clk);
        #1 req_valid = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(we_cnt == w0, "R1 no write after reset", 32'(we_cnt - w0), 32'd0);
        check(mem[2] == shadow[2], "R1 word untouched", mem[2], shadow[2]);
        access(NB + 32'h8, 32'd0, 1'b0, 2'd2);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule